// File: doc/BRIEF.md
# Three-Valued CNF Formula Evaluator

This block judges a fixed conjunctive-normal-form formula against a partial assignment in which every variable is false, true or not yet assigned. The formula is set when the block is elaborated, as two bit masks for each clause. One mask marks the variables that appear as plain literals and the other marks the variables that appear inverted. No memory holds the formula: it becomes gate logic. A branch-and-bound search chain drives the current variable vector in and reads back a single three-valued status. A status of false tells the search to backtrack. A status of true reports a satisfying cover. An undetermined status lets the search go deeper on the current path.

The evaluation uses Kleene logic. Each clause is the three-valued OR of its literals, and the formula is the three-valued AND of its clauses. The same true/false literal terms also produce a two-valued don't-care flag for each variable. A variable is flagged when every clause that mentions it is already satisfied by a literal of some other variable. The search may then set that variable to 0. The block is purely combinational. It has no clock, and no reset acts on it.

Top module: `cnf3_eval`

## Requirements
- R1: Variable i is carried on bits [2i+1:2i] of the input vector. Code 2'b00 means false, 2'b01 means true, and both 2'b10 and 2'b11 mean unassigned.
- R2: The status output uses 2'b00 for false, 2'b01 for true and 2'b10 for undetermined. It never takes the value 2'b11.
- R3: The status is false whenever at least one clause has every one of its literals false.
- R4: The status is true when every clause holds at least one true literal.
- R5: In all other cases the status is undetermined. This includes the case where every variable is unassigned.
- R6: An inverted literal of an unassigned variable is itself unassigned, so a clause with no true literal that still holds such a literal stays undetermined.
- R7: Don't-care bit i is 1 exactly when every clause that contains variable i also holds a true literal of some other variable.
- R8: Don't-care bit i does not depend on the code of variable i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| var_code_i | input | 2*NV | Current assignment, two bits per variable |
| status_o | output | 2 | Three-valued formula status |
| dont_care_o | output | NV | Per-variable don't-care flags |

## Verification
The checker assumes that the input vector holds only known bit values, and it skips its checks while any input bit is unknown. The stimulus always drives every code bit to a defined 0 or 1, and it includes the spare unassigned code 2'b11. Two of the checker's properties assume that the formula has no empty clause: an all-unassigned input can then never be decided. The default formula and every vector in the bench meet that condition. The bench also confirms that a fully assigned vector always yields a decided status.

// File: rtl/cnf3_pkg.sv
// Shared encodings for the three-valued CNF evaluator.
// Assumes: the two-bit code 2'b11 is accepted on inputs as unassigned but
// is never produced on an output.
package cnf3_pkg;

    typedef enum logic [1:0] {
        TV_ZERO = 2'b00,
        TV_ONE  = 2'b01,
        TV_UNK  = 2'b10
    } tv_e;

endpackage

// File: rtl/cnf3_var_decode.sv
// Splits the packed two-bit variable codes into two flat vectors: one flags
// the variables assigned true and the other flags those assigned false.
// Assumes: bit 1 of a code set means unassigned, whatever bit 0 holds.
module cnf3_var_decode #(
    parameter int NV = 4
) (
    input  logic [2*NV-1:0] var_code_i,
    output logic [NV-1:0]   is_one_o,
    output logic [NV-1:0]   is_zero_o
);

    for (genvar v = 0; v < NV; v++) begin : g_var
        // decode one variable's code into its true / false flags
        always_comb begin
            is_one_o[v]  = (var_code_i[2*v+1] == 1'b0) && (var_code_i[2*v] == 1'b1);
            is_zero_o[v] = (var_code_i[2*v+1] == 1'b0) && (var_code_i[2*v] == 1'b0);
        end
    end

endmodule

// File: rtl/cnf3_clause_eval.sv
// Evaluates one clause, given as a plain-literal mask and an inverted-literal
// mask. It gives:
//   sat_o        - some literal of the clause is true
//   fal_o        - every literal of the clause is false (an empty clause is false)
//   other_true_o - per variable: a true literal of a different variable exists
// Assumes: a variable present in both masks makes a literal that can never be
// false, so such a clause is never reported false.
module cnf3_clause_eval #(
    parameter int            NV  = 4,
    parameter logic [NV-1:0] POS = '0,
    parameter logic [NV-1:0] NEG = '0
) (
    input  logic [NV-1:0] is_one_i,
    input  logic [NV-1:0] is_zero_i,
    output logic          sat_o,
    output logic          fal_o,
    output logic [NV-1:0] other_true_o
);

    localparam logic [NV-1:0] PRESENT = POS | NEG;
    localparam logic [NV-1:0] ONLY_P  = POS & ~NEG;
    localparam logic [NV-1:0] ONLY_N  = NEG & ~POS;

    logic [NV-1:0] lit_true;
    logic [NV-1:0] lit_false;

    // per-variable literal truth inside this clause
    always_comb begin
        lit_true  = (POS & is_one_i) | (NEG & is_zero_i);
        lit_false = (ONLY_P & is_zero_i) | (ONLY_N & is_one_i);
    end

    // Kleene OR over the clause literals
    always_comb begin
        sat_o = |lit_true;
        fal_o = &(lit_false | ~PRESENT);
    end

    for (genvar v = 0; v < NV; v++) begin : g_other
        localparam logic [NV-1:0] SELF = NV'(1) << v;
        // true literal among the variables other than v
        always_comb begin
            other_true_o[v] = |(lit_true & ~SELF);
        end
    end

endmodule

// File: rtl/cnf3_status_merge.sv
// Merges the clause results by three-valued AND into one formula status:
// false if any clause is false, true if all clauses are satisfied, otherwise
// undetermined.
// Assumes: a clause never reports true and false at once.
module cnf3_status_merge #(
    parameter int NC = 3
) (
    input  logic [NC-1:0] sat_i,
    input  logic [NC-1:0] fal_i,
    output logic [1:0]    status_o
);

    import cnf3_pkg::*;

    // Kleene AND, with a false clause taking priority
    always_comb begin
        if (|fal_i) begin
            status_o = TV_ZERO;
        end else if (&sat_i) begin
            status_o = TV_ONE;
        end else begin
            status_o = TV_UNK;
        end
    end

endmodule

// File: rtl/cnf3_dont_care.sv
// Gives a two-valued don't-care flag for each variable. Variable v is flagged
// when every clause that mentions it holds a true literal of another
// variable. A variable found in no clause is flagged.
// Assumes: other_true_i is clause-major: clause c, variable v at c*NV+v.
module cnf3_dont_care #(
    parameter int                  NV       = 4,
    parameter int                  NC       = 3,
    parameter logic [NC*NV-1:0]    POS_MASK = '0,
    parameter logic [NC*NV-1:0]    NEG_MASK = '0
) (
    input  logic [NC*NV-1:0] other_true_i,
    output logic [NV-1:0]    dont_care_o
);

    localparam logic [NC*NV-1:0] OCCURS = POS_MASK | NEG_MASK;

    for (genvar v = 0; v < NV; v++) begin : g_var
        logic [NC-1:0] covered;
        for (genvar c = 0; c < NC; c++) begin : g_cl
            // clause c does not block the flag for v
            always_comb begin
                covered[c] = !OCCURS[c*NV+v] || other_true_i[c*NV+v];
            end
        end
        // all clauses agree
        always_comb begin
            dont_care_o[v] = &covered;
        end
    end

endmodule

// File: rtl/cnf3_eval.sv
// Top of the three-valued CNF evaluator. It decodes the assignment, evaluates
// each clause in its own generated slice, and then merges the clause results
// into the formula status and the don't-care flags.
// Assumes: the formula is fixed by POS_MASK / NEG_MASK, clause c in bits
// [c*NV +: NV], and bit v of a slice belongs to variable v.
module cnf3_eval #(
    parameter int               NV       = 4,
    parameter int               NC       = 3,
    parameter logic [NC*NV-1:0] POS_MASK = 12'b0100_0100_0011,
    parameter logic [NC*NV-1:0] NEG_MASK = 12'b1000_0011_0000
) (
    input  logic [2*NV-1:0] var_code_i,
    output logic [1:0]      status_o,
    output logic [NV-1:0]   dont_care_o
);

    logic [NV-1:0]    is_one;
    logic [NV-1:0]    is_zero;
    logic [NC-1:0]    cl_sat;
    logic [NC-1:0]    cl_fal;
    logic [NC*NV-1:0] cl_other;

    cnf3_var_decode #(.NV(NV)) u_dec (
        .var_code_i (var_code_i),
        .is_one_o   (is_one),
        .is_zero_o  (is_zero)
    );

    for (genvar c = 0; c < NC; c++) begin : g_clause
        cnf3_clause_eval #(
            .NV  (NV),
            .POS (POS_MASK[c*NV +: NV]),
            .NEG (NEG_MASK[c*NV +: NV])
        ) u_cl (
            .is_one_i     (is_one),
            .is_zero_i    (is_zero),
            .sat_o        (cl_sat[c]),
            .fal_o        (cl_fal[c]),
            .other_true_o (cl_other[c*NV +: NV])
        );
    end

    cnf3_status_merge #(.NC(NC)) u_merge (
        .sat_i    (cl_sat),
        .fal_i    (cl_fal),
        .status_o (status_o)
    );

    cnf3_dont_care #(
        .NV       (NV),
        .NC       (NC),
        .POS_MASK (POS_MASK),
        .NEG_MASK (NEG_MASK)
    ) u_dc (
        .other_true_i (cl_other),
        .dont_care_o  (dont_care_o)
    );

endmodule

// File: rtl/cnf3_eval_chk.sv
// Assertion checker for cnf3_eval, attached by bind. The block has no clock,
// so every check is an immediate assertion on settled port values. Checks are
// skipped while any input bit is unknown.
module cnf3_eval_chk #(
    parameter int               NV       = 4,
    parameter int               NC       = 3,
    parameter logic [NC*NV-1:0] POS_MASK = '0,
    parameter logic [NC*NV-1:0] NEG_MASK = '0
) (
    input logic [2*NV-1:0] var_code_i,
    input logic [1:0]      status_o,
    input logic [NV-1:0]   dont_care_o
);

    logic [NV-1:0] unk;
    logic [NV-1:0] occurs;
    logic          empty_cl;

    // per-variable unassigned flags, occurrence mask and empty-clause flag
    always_comb begin
        occurs   = '0;
        empty_cl = 1'b0;
        for (int v = 0; v < NV; v++) begin
            unk[v] = var_code_i[2*v+1];
        end
        for (int c = 0; c < NC; c++) begin
            occurs = occurs | POS_MASK[c*NV +: NV] | NEG_MASK[c*NV +: NV];
            if ((POS_MASK[c*NV +: NV] | NEG_MASK[c*NV +: NV]) == '0) begin
                empty_cl = 1'b1;
            end
        end
    end

    // output relations
    always_comb begin
        if (!$isunknown(var_code_i)) begin
            // R2
            status_code_chk: assert (status_o != 2'b11)
                else $error("status took the spare code");
            // R5
            full_assign_decided_chk: assert (!(unk == '0) || status_o != 2'b10)
                else $error("complete assignment left undetermined");
            // R5
            all_unk_open_chk: assert (!((&unk) && !empty_cl) || status_o == 2'b10)
                else $error("empty assignment decided");
            // R7
            all_unk_dc_chk: assert (!(&unk) || dont_care_o == ~occurs)
                else $error("don't-care set without a true literal");
        end
    end

endmodule

bind cnf3_eval cnf3_eval_chk #(
    .NV       (NV),
    .NC       (NC),
    .POS_MASK (POS_MASK),
    .NEG_MASK (NEG_MASK)
) u_chk (
    .var_code_i  (var_code_i),
    .status_o    (status_o),
    .dont_care_o (dont_care_o)
);

// File: tb/sim_cnf3_eval.sv
// Bench for cnf3_eval with its default formula over variables a,b,c,d
// (index 0..3): (a | b) & (~a | ~b | c) & (c | ~d).
module sim_cnf3_eval;

    localparam int NV = 4;
    localparam logic [1:0] Z = 2'b00;
    localparam logic [1:0] O = 2'b01;
    localparam logic [1:0] U = 2'b10;
    localparam logic [1:0] W = 2'b11;
    localparam int NVEC = 12;

    // input vectors, packed {d,c,b,a}
    localparam logic [7:0] VEC_IN [NVEC] = '{
        {U,U,U,U}, {U,U,Z,O}, {U,Z,O,O}, {O,O,O,O},
        {U,U,Z,Z}, {Z,U,O,Z}, {Z,Z,O,U}, {O,Z,O,Z},
        {O,O,Z,O}, {Z,Z,O,W}, {O,O,O,Z}, {O,O,O,U}
    };
    localparam logic [1:0] VEC_ST [NVEC] = '{
        U, U, Z, O,
        Z, O, U, Z,
        O, U, O, O
    };
    localparam logic [3:0] VEC_DC [NVEC] = '{
        4'b0000, 4'b0000, 4'b0000, 4'b1011,
        4'b0000, 4'b0100, 4'b0000, 4'b0000,
        4'b1010, 4'b0000, 4'b1001, 4'b1001
    };

    logic clk = 1'b0;
    logic [2*NV-1:0] var_code;
    logic [1:0]      status;
    logic [NV-1:0]   dc;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cnf3_eval u0 (
        .var_code_i  (var_code),
        .status_o    (status),
        .dont_care_o (dc)
    );

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:     return "R5";
            2, 4, 7:  return "R3";
            3:        return "R4";
            5, 8:     return "R7";
            6:        return "R6";
            9:        return "R1";
            default:  return "R8";
        endcase
    endfunction

    task automatic check2(input string tag, input string what,
                          input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] v);
        @(posedge clk);
        var_code = v;
        @(negedge clk);
    endtask

    initial begin
        var_code = {U,U,U,U};
        // power-up state: nothing assigned (R5)
        @(negedge clk);
        check2("R5", "initial status", {2'b00, status}, {2'b00, U});
        check2("R5", "initial dont-care", dc, 4'b0000);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC_IN[i]);
            check2(vec_tag(i), "status", {2'b00, status}, {2'b00, VEC_ST[i]});
            check2(vec_tag(i), "dont-care", dc, VEC_DC[i]);
            // R2: spare status code never appears
            check2("R2", "status not 11", {3'b000, status == 2'b11}, 4'b0000);
        end

        // R8: flag of a stays set whatever a holds (b=c=d=1)
        for (int k = 0; k < 4; k++) begin
            apply({O, O, O, 2'(k)});
            check2("R8", "dont-care of a", {3'b000, dc[0]}, 4'b0001);
        end

        // R1 / R6: spare unassigned code on b keeps clause 0 open (a=0,c=1,d=0)
        apply({Z, O, W, Z});
        check2("R1", "status with b=11", {2'b00, status}, {2'b00, U});
        // R3: assigning b=0 then falsifies clause 0
        apply({Z, O, Z, Z});
        check2("R3", "status with a=b=0", {2'b00, status}, {2'b00, Z});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule